// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block works out how a serial port's bit clock should be derived from a source clock. Given a source frequency and a requested baud rate, both as 32-bit integers, it tries every oversampling ratio from 4 to 32. For each ratio it picks the integer divider that comes closest to the requested rate and keeps the best ratio and divider pair seen so far. When the search ends it reports the chosen ratio, the divider, the absolute rate error, and whether that error is small enough to use.

The block is driven by a start pulse. The source frequency and baud rate are sampled on that pulse. A single iterative divider, producing one quotient bit per cycle, is shared by every division in the search. When the results are ready, a one-cycle done pulse is raised. The results then stay on the outputs until the next accepted start. Writing the results into a baud generator is left to the surrounding logic.

Top module: `baud_srch_top`

## Requirements
- R1: After reset, done, busy and supported are 0, and osr_best, div_best and err_best are all 0.
- R2: A start accepted with baud equal to 0 skips the search. In the next cycle done is 1, supported is 0, and osr_best, div_best and err_best are 0.
- R3: For each ratio r from 4 to 32, in increasing order, the trial divider is floor(src_hz / (baud * r)), and a trial divider of 0 is replaced by 1. The achieved rate for divider d is floor(src_hz / (r * d)), and its error is the absolute difference from baud.
- R4: For each ratio, the trial divider d is replaced by d+1 only when the error with d+1 is strictly smaller than the error with d.
- R5: The best error starts at the baud value. A ratio's candidate replaces the best when its error is less than or equal to the best error, so on a tie the larger ratio wins.
- R6: supported is 1 exactly when err_best <= floor(baud / 100) * 3.
- R7: busy is 1 from the cycle after a start with nonzero baud is accepted until the results appear. done is a single-cycle pulse that coincides with the results and with busy falling.
- R8: A start raised while busy is ignored. The outputs keep their values from one done to the next accepted start.
- R9: src_hz and baud are sampled when start is accepted. Changing them during a search has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; taken only while idle |
| src_hz | input | 32 | Source clock frequency in Hz |
| baud | input | 32 | Requested baud rate |
| done | output | 1 | One-cycle pulse when results are valid |
| busy | output | 1 | Search in progress |
| osr_best | output | 6 | Chosen oversampling ratio (4 to 32; 0 when baud is 0) |
| div_best | output | 32 | Chosen integer divider |
| err_best | output | 32 | Absolute error between achieved and requested baud |
| supported | output | 1 | Error is within 3 percent of baud |

## Verification
Most internal faults are only visible in the results at done, which arrives about three thousand cycles after start. Examples are a wrong quotient bit in the shared divider, an off-by-one in the ratio counter, or a strict comparison where a tie should replace the best. Each of these shows up as a wrong ratio, divider or error, or as a flipped supported flag. Two kinds of input are chosen so that these fault classes are not masked. Some cases produce many equal errors, such as a zero source clock or exact divisions. Others need the divider to be rounded up. A faulty control state shows up sooner: busy does not rise one cycle after start, done lasts more than one cycle, or the outputs move between searches.

// File: rtl/baud_srch_pkg.sv
package baud_srch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUOT,
        ST_RATE_LO,
        ST_RATE_HI,
        ST_LIMIT
    } srch_state_e;
endpackage

// File: rtl/baud_srch_div.sv
module baud_srch_div #(
    parameter int N = 32,
    parameter int D = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quotient
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [D:0]    rem;
        logic [N-1:0]  quo;
        logic [D-1:0]  dvs;
    } div_reg_t;

    div_reg_t r_q, r_d;
    logic [D:0] trial;
    logic       fits;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem[D-1:0], r_q.quo[N-1]};
        fits     = (trial >= {1'b0, r_q.dvs});
        if (go) begin
            r_d.run = 1'b1;
            r_d.cnt = CW'(N);
            r_d.rem = '0;
            r_d.quo = dividend;
            r_d.dvs = divisor;
        end else if (r_q.run) begin
            r_d.rem = fits ? (trial - {1'b0, r_q.dvs}) : trial;
            r_d.quo = {r_q.quo[N-2:0], fits};
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done     = r_q.done;
    assign quotient = r_q.quo;
endmodule

// File: rtl/baud_srch_absdiff.sv
module baud_srch_absdiff #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff
);
    always_comb begin
        if (a >= b) diff = a - b;
        else        diff = b - a;
    end
endmodule

// File: rtl/baud_srch_top.sv
module baud_srch_top
    import baud_srch_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int OSR_MIN = 4,
    parameter int OSR_MAX = 32,
    parameter int PCT_NUM = 3,
    parameter int PCT_DEN = 100,
    parameter int OSR_W   = $clog2(OSR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] src_hz,
    input  logic [WIDTH-1:0] baud,
    output logic             done,
    output logic             busy,
    output logic [OSR_W-1:0] osr_best,
    output logic [WIDTH-1:0] div_best,
    output logic [WIDTH-1:0] err_best,
    output logic             supported
);
    localparam int DVS_W = WIDTH + OSR_W;
    localparam int LIM_W = WIDTH + 2;

    typedef struct packed {
        srch_state_e      st;
        logic             go;
        logic [WIDTH-1:0] dvd;
        logic [DVS_W-1:0] dvs;
        logic [WIDTH-1:0] src;
        logic [WIDTH-1:0] bd;
        logic [OSR_W-1:0] osr;
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] e1;
        logic [WIDTH-1:0] b_err;
        logic [OSR_W-1:0] b_osr;
        logic [WIDTH-1:0] b_div;
        logic [OSR_W-1:0] o_osr;
        logic [WIDTH-1:0] o_div;
        logic [WIDTH-1:0] o_err;
        logic             o_sup;
        logic             done;
    } top_reg_t;

    top_reg_t r_q, r_d;

    logic             div_done;
    logic [WIDTH-1:0] div_quo;
    logic [WIDTH-1:0] err_now;
    logic [WIDTH-1:0] qv;
    logic [WIDTH-1:0] cand_e;
    logic [WIDTH-1:0] cand_q;
    logic [OSR_W-1:0] osr_nx;
    logic [LIM_W-1:0] limit;

    baud_srch_div #(.N(WIDTH), .D(DVS_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (r_q.go),
        .dividend (r_q.dvd),
        .divisor  (r_q.dvs),
        .done     (div_done),
        .quotient (div_quo)
    );

    baud_srch_absdiff #(.W(WIDTH)) u_err (
        .a    (div_quo),
        .b    (r_q.bd),
        .diff (err_now)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        qv       = (div_quo == '0) ? WIDTH'(1) : div_quo;
        osr_nx   = r_q.osr + 1'b1;
        limit    = LIM_W'(div_quo) * LIM_W'(PCT_NUM);
        if (r_q.e1 > err_now) begin
            cand_e = err_now;
            cand_q = r_q.q + 1'b1;
        end else begin
            cand_e = r_q.e1;
            cand_q = r_q.q;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (baud == '0) begin
                        r_d.o_osr = '0;
                        r_d.o_div = '0;
                        r_d.o_err = '0;
                        r_d.o_sup = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.src   = src_hz;
                        r_d.bd    = baud;
                        r_d.b_err = baud;
                        r_d.b_osr = '0;
                        r_d.b_div = '0;
                        r_d.osr   = OSR_W'(OSR_MIN);
                        r_d.dvd   = src_hz;
                        r_d.dvs   = DVS_W'(baud) * DVS_W'(OSR_MIN);
                        r_d.go    = 1'b1;
                        r_d.st    = ST_QUOT;
                    end
                end
            end
            ST_QUOT: begin
                if (div_done) begin
                    r_d.q   = qv;
                    r_d.dvs = DVS_W'(r_q.osr) * DVS_W'(qv);
                    r_d.go  = 1'b1;
                    r_d.st  = ST_RATE_LO;
                end
            end
            ST_RATE_LO: begin
                if (div_done) begin
                    r_d.e1  = err_now;
                    r_d.dvs = DVS_W'(r_q.osr) * DVS_W'(r_q.q + 1'b1);
                    r_d.go  = 1'b1;
                    r_d.st  = ST_RATE_HI;
                end
            end
            ST_RATE_HI: begin
                if (div_done) begin
                    if (cand_e <= r_q.b_err) begin
                        r_d.b_err = cand_e;
                        r_d.b_osr = r_q.osr;
                        r_d.b_div = cand_q;
                    end
                    r_d.go = 1'b1;
                    if (r_q.osr == OSR_W'(OSR_MAX)) begin
                        r_d.dvd = r_q.bd;
                        r_d.dvs = DVS_W'(PCT_DEN);
                        r_d.st  = ST_LIMIT;
                    end else begin
                        r_d.osr = osr_nx;
                        r_d.dvd = r_q.src;
                        r_d.dvs = DVS_W'(r_q.bd) * DVS_W'(osr_nx);
                        r_d.st  = ST_QUOT;
                    end
                end
            end
            ST_LIMIT: begin
                if (div_done) begin
                    r_d.o_osr = r_q.b_osr;
                    r_d.o_div = r_q.b_div;
                    r_d.o_err = r_q.b_err;
                    r_d.o_sup = (LIM_W'(r_q.b_err) <= limit);
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done      = r_q.done;
    assign busy      = (r_q.st != ST_IDLE);
    assign osr_best  = r_q.o_osr;
    assign div_best  = r_q.o_div;
    assign err_best  = r_q.o_err;
    assign supported = r_q.o_sup;
endmodule

// File: rtl/baud_srch_chk.sv
module baud_srch_chk #(
    parameter int WIDTH   = 32,
    parameter int OSR_MIN = 4,
    parameter int OSR_MAX = 32,
    parameter int OSR_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] baud,
    input logic             done,
    input logic             busy,
    input logic [OSR_W-1:0] osr_best,
    input logic [WIDTH-1:0] div_best,
    input logic [WIDTH-1:0] err_best,
    input logic             supported
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && baud != '0) |=> (busy && !done));

    assert_zero_baud_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && baud == '0) |=> (done && !supported && osr_best == '0 && div_best == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({osr_best, div_best, err_best, supported}));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({osr_best, div_best, err_best, supported}));

    assert_ratio_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && supported) |-> (osr_best >= OSR_W'(OSR_MIN) && osr_best <= OSR_W'(OSR_MAX) && div_best != '0));
endmodule

bind baud_srch_top baud_srch_chk #(
    .WIDTH   (WIDTH),
    .OSR_MIN (OSR_MIN),
    .OSR_MAX (OSR_MAX),
    .OSR_W   (OSR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .baud      (baud),
    .done      (done),
    .busy      (busy),
    .osr_best  (osr_best),
    .div_best  (div_best),
    .err_best  (err_best),
    .supported (supported)
);

// File: tb/baud_srch_top_tb.sv
module baud_srch_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_MAX   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_hz = '0;
    logic [31:0] baud = '0;
    logic        done;
    logic        busy;
    logic [5:0]  osr_best;
    logic [31:0] div_best;
    logic [31:0] err_best;
    logic        supported;

    int n_chk = 0;
    int n_bad = 0;

    baud_srch_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_hz    (src_hz),
        .baud      (baud),
        .done      (done),
        .busy      (busy),
        .osr_best  (osr_best),
        .div_best  (div_best),
        .err_best  (err_best),
        .supported (supported)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected results of a search, from R3..R6.
    task automatic ref_search(input longint unsigned s, input longint unsigned b,
                              output longint unsigned e_osr, output longint unsigned e_div,
                              output longint unsigned e_err, output longint unsigned e_sup);
        longint unsigned best, q, a1, a2, d1, d2, e, qq;
        best = b; e_osr = 0; e_div = 0;
        for (int r = 4; r <= 32; r++) begin
            q  = s / (b * longint'(r));
            if (q == 0) q = 1;
            a1 = s / (longint'(r) * q);
            a2 = s / (longint'(r) * (q + 1));
            d1 = (a1 >= b) ? a1 - b : b - a1;
            d2 = (a2 >= b) ? a2 - b : b - a2;
            if (d1 > d2) begin e = d2; qq = q + 1; end
            else begin e = d1; qq = q; end
            if (e <= best) begin best = e; e_osr = r; e_div = qq; end
        end
        e_err = best;
        e_sup = (best <= (b / 100) * 3) ? 1 : 0;
    endtask

    task automatic pulse_start(input logic [31:0] s, input logic [31:0] b);
        @(negedge clk);
        src_hz = s;
        baud   = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
        check(req, "done seen", done, 1);
    endtask

    task automatic compare_result(input string req, input logic [31:0] s, input logic [31:0] b);
        longint unsigned eo, ed, ee, es;
        ref_search(s, b, eo, ed, ee, es);
        check(req, "osr_best", osr_best, eo);
        check(req, "div_best", div_best, ed);
        check(req, "err_best", err_best, ee);
        check("R6", "supported", supported, es);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "done", done, 0);
        check("R1", "busy", busy, 0);
        check("R1", "supported", supported, 0);
        check("R1", "osr_best", osr_best, 0);
        check("R1", "div_best", div_best, 0);
        check("R1", "err_best", err_best, 0);
    endtask

    // Normal search; R3/R4/R5 through the reference, R7 on handshake timing.
    task automatic t_search(input string req, input logic [31:0] s, input logic [31:0] b);
        pulse_start(s, b);
        check("R7", "busy after start", busy, 1);
        check("R7", "done early", done, 0);
        wait_done("R7");
        check("R7", "busy at done", busy, 0);
        compare_result(req, s, b);
        @(negedge clk);
        check("R7", "done width", done, 0);
    endtask

    task automatic t_zero_baud();
        pulse_start(32'd48000000, 32'd0);
        check("R2", "done", done, 1);
        check("R2", "busy", busy, 0);
        check("R2", "supported", supported, 0);
        check("R2", "osr_best", osr_best, 0);
        check("R2", "div_best", div_best, 0);
        check("R2", "err_best", err_best, 0);
        @(negedge clk);
        check("R2", "done width", done, 0);
    endtask

    // Start while busy and input changes mid-search (R8, R9), then hold (R8).
    task automatic t_ignore_and_hold();
        logic [5:0]  h_osr;
        logic [31:0] h_div, h_err;
        logic        h_sup;
        pulse_start(32'd24000000, 32'd57600);
        repeat (100) @(negedge clk);
        src_hz = 32'd1000;
        baud   = 32'd300;
        repeat (50) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        compare_result("R9", 32'd24000000, 32'd57600);
        h_osr = osr_best; h_div = div_best; h_err = err_best; h_sup = supported;
        src_hz = 32'd5;
        baud   = 32'd7;
        repeat (40) @(negedge clk);
        check("R8", "busy after extra start", busy, 0);
        check("R8", "osr hold", osr_best, h_osr);
        check("R8", "div hold", div_best, h_div);
        check("R8", "err hold", err_best, h_err);
        check("R8", "sup hold", supported, h_sup);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_search("R3", 32'd48000000, 32'd115200);
        t_search("R4", 32'd8000000,  32'd9600);
        t_search("R5", 32'd0,        32'd9600);
        t_search("R3", 32'd1000,     32'd115200);
        t_search("R3", 32'd1000000,  32'd1000000);
        t_search("R4", 32'hFFFFFFFF, 32'd1);
        t_search("R5", 32'd4000,     32'd50);
        t_search("R4", 32'd3000000,  32'd100000);
        t_search("R6", 32'd20971520, 32'd230400);
        t_zero_baud();
        t_ignore_and_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule